// File: doc/BRIEF.md
# General-Purpose I/O Controller with Edge Interrupts

This block controls 32 general-purpose pins from a simple 32-bit register bus. Software picks a direction for each pin. It can put an output pin into open-drain operation and set its output level. The block samples the pin inputs through a two-stage synchronizer and compares each synchronized level with its value one cycle earlier to find edges. Detected edges set bits in a sticky event register. One interrupt line is raised while any event bit is set together with its enable bit.

Register bits are numbered from the most significant end: pin 0 sits in bit 31 and pin 31 sits in bit 0. The pin ports are indexed by pin number, so the block reverses the bit order between the pad side and the register side. Reading the level word gives the written value for output pins and the sampled input for input pins. An open-drain output that something outside holds low therefore still reads back the value software last wrote. Each pin has a mode bit that selects falling-edge-only or both-edge capture. Pending events are cleared by writing ones.

Top module: `gpio_ctrl`

## Requirements
- R1: Pin p (port bit p of pin_in, pin_out and pin_oe) corresponds to register bit 31-p in every register, so pin 0 is bit 31.
- R2: Byte offsets are: 0x00 direction, 0x04 open-drain select, 0x08 level, 0x0C events, 0x10 enables, 0x14 edge mode. Reads of 0x18 and 0x1C return zero. After reset every register reads zero, no pin is driven and irq is low.
- R3: A direction bit of 1 makes the pin an output, so pin_oe can be 1. A direction bit of 0 makes it an input and pin_oe is 0.
- R4: pin_out follows the written level bit. When the open-drain bit is 1, an output pin asserts pin_oe only while its level bit is 0. The block never drives an open-drain pin high.
- R5: Reading offset 0x08 returns the written level for output pins and the synchronized pin_in value for input pins.
- R6: A change on pin_in shows in the 0x08 read after two rising clock edges. The matching event bit is set at the third edge.
- R7: When a pin's edge-mode bit is 0, both rising and falling edges set its event bit. When the bit is 1, only falling edges do.
- R8: A write to 0x0C clears each event bit written as 1 and leaves bits written as 0 unchanged. Writing 0xFFFFFFFF clears all events.
- R9: If a pin's edge is captured in the same cycle as a write that clears its event bit, the bit stays set.
- R10: irq is 1 exactly when the bitwise AND of the event and enable registers is nonzero. An enable bit of 1 lets that pin interrupt.
- R11: An event bit stays set until a clear write removes it, whatever the pin does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| pin_in | input | 32 | Pad input levels, indexed by pin number |
| pin_out | output | 32 | Pad output values, indexed by pin number |
| pin_oe | output | 32 | Pad output enables, indexed by pin number |
| irq | output | 1 | Interrupt request |

## Verification
The readback path is tried with four direction, open-drain, level and input mixes. These include an all-output word, an all-input word, an all-open-drain word with the inputs held low, and a split word. Together they separate the output-latch path from the input path, and the push-pull enable from the open-drain enable. Edge capture is tried with single-pin rising and falling steps in both edge modes, which separates the falling-only mode from both-edge capture. Further tests cover a partial clear next to a full clear, and an edge that lands in the same cycle as its clear, which separates the priority of capture over clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // word index = byte address [4:2]
  typedef enum logic [2:0] {
    WI_DIR = 3'd0,
    WI_ODE = 3'd1,
    WI_LVL = 3'd2,
    WI_EVT = 3'd3,
    WI_ENA = 3'd4,
    WI_MOD = 3'd5
  } word_e;

  localparam int unsigned WORD_IDX_W = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st1_q, st2_q;
  logic [W-1:0] st1_d, st2_d;

  always_comb begin
    st1_d = d;
    st2_d = st1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= st1_d;
      st2_q <= st2_d;
    end
  end

  assign q = st2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  in_sync,
  input  logic [W-1:0]  evt,
  output logic [W-1:0]  dir,
  output logic [W-1:0]  ode,
  output logic [W-1:0]  lvl,
  output logic [W-1:0]  ena,
  output logic [W-1:0]  mode,
  output logic [W-1:0]  evt_clr
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + WORD_IDX_W - 1;

  logic [WORD_IDX_W-1:0] widx;
  logic                  wr, rd;
  logic [W-1:0] dir_d, ode_d, lvl_d, ena_d, mode_d;
  logic         dir_ce, ode_ce, lvl_ce, ena_ce, mode_ce;

  assign widx = bus_addr[IDX_HI:IDX_LO];
  assign wr   = bus_en &  bus_we;
  assign rd   = bus_en & ~bus_we;

  always_comb begin
    dir_ce  = wr && (widx == WI_DIR);
    ode_ce  = wr && (widx == WI_ODE);
    lvl_ce  = wr && (widx == WI_LVL);
    ena_ce  = wr && (widx == WI_ENA);
    mode_ce = wr && (widx == WI_MOD);
    dir_d   = bus_wdata;
    ode_d   = bus_wdata;
    lvl_d   = bus_wdata;
    ena_d   = bus_wdata;
    mode_d  = bus_wdata;
    evt_clr = (wr && (widx == WI_EVT)) ? bus_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir  <= '0;
      ode  <= '0;
      lvl  <= '0;
      ena  <= '0;
      mode <= '0;
    end else begin
      if (dir_ce)  dir  <= dir_d;
      if (ode_ce)  ode  <= ode_d;
      if (lvl_ce)  lvl  <= lvl_d;
      if (ena_ce)  ena  <= ena_d;
      if (mode_ce) mode <= mode_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (widx)
        WI_DIR:  bus_rdata = dir;
        WI_ODE:  bus_rdata = ode;
        WI_LVL:  bus_rdata = (lvl & dir) | (in_sync & ~dir);
        WI_EVT:  bus_rdata = evt;
        WI_ENA:  bus_rdata = ena;
        WI_MOD:  bus_rdata = mode;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R2: holes in the map never return data
  assert_hole_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (widx > WI_MOD)) |-> (bus_rdata == '0));
endmodule

// File: rtl/gpio_events.sv
module gpio_events #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_sync,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] ena,
  input  logic [W-1:0] evt_clr,
  output logic [W-1:0] evt,
  output logic         irq
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall, cap;
  logic [W-1:0] evt_d;
  logic         irq_d;

  always_comb begin
    rise  = in_sync & ~prev_q;
    fall  = ~in_sync & prev_q;
    cap   = fall | (rise & ~mode);
    // capture wins over a simultaneous clear
    evt_d = (evt & ~evt_clr) | cap;
    irq_d = |(evt & ena);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt    <= '0;
    end else begin
      prev_q <= in_sync;
      evt    <= evt_d;
    end
  end

  assign irq = irq_d;

  // R8: a cleared bit with no competing capture is gone next cycle
  assert_evt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_clr & ~cap)) |=> ((evt & $past(evt_clr & ~cap)) == '0));

  // R9: a capture colliding with a clear keeps the bit
  assert_clear_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_clr & cap)) |=> ((evt & $past(evt_clr & cap)) == $past(evt_clr & cap)));

  // R11: set bits survive unless cleared
  assert_evt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((evt & $past(evt & ~evt_clr)) == $past(evt & ~evt_clr)));

  // R7: falling-only pins never gain an event without a falling edge
  assert_fall_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((evt & ~$past(evt) & $past(mode) & ~$past(fall)) == '0));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_q;
  logic                  rst_ln;
  logic [NPIN-1:0] in_reg, in_sync;
  logic [NPIN-1:0] dir, ode, lvl, ena, mode, evt, evt_clr;
  logic [NPIN-1:0] drv_en;
  logic [NPIN-1:0] ode_pin, dir_pin;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_ln = rst_q[RST_STAGES-1];

  // pin p <-> register bit NPIN-1-p
  for (genvar p = 0; p < NPIN; p++) begin : g_pinmap
    assign in_reg[NPIN-1-p] = pin_in[p];
    assign pin_out[p]       = lvl[NPIN-1-p];
    assign pin_oe[p]        = drv_en[NPIN-1-p];
    assign ode_pin[p]       = ode[NPIN-1-p];
    assign dir_pin[p]       = dir[NPIN-1-p];
  end

  assign drv_en = dir & ~(ode & lvl);

  gpio_sync #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_ln),
    .d     (in_reg),
    .q     (in_sync)
  );

  gpio_regs #(.W(NPIN), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_ln),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .in_sync   (in_sync),
    .evt       (evt),
    .dir       (dir),
    .ode       (ode),
    .lvl       (lvl),
    .ena       (ena),
    .mode      (mode),
    .evt_clr   (evt_clr)
  );

  gpio_events #(.W(NPIN)) u_evt (
    .clk     (clk),
    .rst_n   (rst_ln),
    .in_sync (in_sync),
    .mode    (mode),
    .ena     (ena),
    .evt_clr (evt_clr),
    .evt     (evt),
    .irq     (irq)
  );

  // R4: open-drain pins are never driven high
  assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!rst_ln)
    ((pin_oe & pin_out & ode_pin) == '0));

  // R3: input pins are never driven
  assert_input_undriven_R3: assert property (@(posedge clk) disable iff (!rst_ln)
    ((pin_oe & ~dir_pin) == '0));
endmodule

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam logic [4:0] A_DIR = 5'h00, A_ODE = 5'h04, A_LVL = 5'h08,
                         A_EVT = 5'h0C, A_ENA = 5'h10, A_MOD = 5'h14;

  // register-order stimulus and expectations
  localparam logic [31:0] V_DIR [NV] = '{32'hFFFF0000, 32'h00000000, 32'hFFFFFFFF, 32'h0F0F0F0F};
  localparam logic [31:0] V_ODE [NV] = '{32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00FF00FF};
  localparam logic [31:0] V_LVL [NV] = '{32'hA5A5A5A5, 32'hFFFFFFFF, 32'hF0F0F0F0, 32'h3C3C3C3C};
  localparam logic [31:0] V_PIN [NV] = '{32'h12345678, 32'hDEADBEEF, 32'h00000000, 32'hFFFF0000};
  localparam logic [31:0] V_RD  [NV] = '{32'hA5A55678, 32'hDEADBEEF, 32'hF0F0F0F0, 32'hFCFC0C0C};
  localparam logic [31:0] V_OE  [NV] = '{32'hFFFF0000, 32'h00000000, 32'h0F0F0F0F, 32'h0F030F03};

  logic clk, rst_n, bus_en, bus_we, irq;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  int n_chk, n_bad;
  bit done;

  gpio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R2 reset state and map holes
    rd_chk("R2 dir reset", A_DIR, 32'h0);
    rd_chk("R2 ode reset", A_ODE, 32'h0);
    rd_chk("R2 lvl reset", A_LVL, 32'h0);
    rd_chk("R2 evt reset", A_EVT, 32'h0);
    rd_chk("R2 ena reset", A_ENA, 32'h0);
    rd_chk("R2 mod reset", A_MOD, 32'h0);
    chk("R2 oe reset", pin_oe, 32'h0);
    chk("R2 irq reset", {31'b0, irq}, 32'h0);
    wr(A_MOD, 32'h12345678);
    rd_chk("R2 mod readback", A_MOD, 32'h12345678);
    rd_chk("R2 hole 0x18", 5'h18, 32'h0);
    rd_chk("R2 hole 0x1C", 5'h1C, 32'h0);
    wr(A_MOD, 32'h0);

    // R3 R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      wr(A_DIR, V_DIR[i]);
      wr(A_ODE, V_ODE[i]);
      wr(A_LVL, V_LVL[i]);
      pin_in = rev(V_PIN[i]);
      cyc(2);
      rd_chk("R5 R6 level readback", A_LVL, V_RD[i]);
      chk("R3 R4 pin_oe", pin_oe, rev(V_OE[i]));
      chk("R4 pin_out", pin_out, rev(V_LVL[i]));
    end
    wr(A_DIR, 32'h0); wr(A_ODE, 32'h0); wr(A_LVL, 32'h0);
    pin_in = '0;
    cyc(4);
    wr(A_EVT, 32'hFFFFFFFF);
    rd_chk("R8 clear all", A_EVT, 32'h0);

    // R1 bit order
    wr(A_DIR, 32'h80000000);
    wr(A_LVL, 32'h80000000);
    chk("R1 pin0 oe", pin_oe, 32'h00000001);
    chk("R1 pin0 out", pin_out, 32'h00000001);
    wr(A_DIR, 32'h0); wr(A_LVL, 32'h0);

    // R6 timing, R10 masking
    pin_in[0] = 1'b1;
    cyc(2);
    rd_chk("R6 level after two edges", A_LVL, 32'h80000000);
    rd_chk("R6 no event yet", A_EVT, 32'h0);
    cyc(1);
    rd_chk("R6 R7 rising captured", A_EVT, 32'h80000000);
    chk("R10 masked irq", {31'b0, irq}, 32'h0);
    wr(A_ENA, 32'h80000000);
    chk("R10 enabled irq", {31'b0, irq}, 32'h1);
    wr(A_EVT, 32'h7FFFFFFF);
    rd_chk("R8 zeros keep bit", A_EVT, 32'h80000000);
    wr(A_EVT, 32'h80000000);
    rd_chk("R8 one clears bit", A_EVT, 32'h0);
    chk("R10 irq drops", {31'b0, irq}, 32'h0);

    // R7 edge mode
    wr(A_MOD, 32'h40000000);
    pin_in[1] = 1'b1;
    cyc(4);
    rd_chk("R7 falling-only ignores rise", A_EVT, 32'h0);
    pin_in[1] = 1'b0;
    cyc(4);
    rd_chk("R7 falling-only takes fall", A_EVT, 32'h40000000);
    pin_in[0] = 1'b0;
    cyc(4);
    rd_chk("R7 both-edge takes fall", A_EVT, 32'hC0000000);
    wr(A_ENA, 32'h20000000);
    chk("R10 other pin enabled only", {31'b0, irq}, 32'h0);
    pin_in[0] = 1'b1;
    cyc(10);
    rd_chk("R11 sticky events", A_EVT, 32'hC0000000);
    pin_in[0] = 1'b0;
    cyc(4);
    wr(A_EVT, 32'hFFFFFFFF);
    rd_chk("R8 full clear", A_EVT, 32'h0);

    // R9 capture and clear in the same cycle
    wr(A_ENA, 32'h80000000);
    @(negedge clk);
    pin_in[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    wr(A_EVT, 32'h80000000);
    rd_chk("R9 capture beats clear", A_EVT, 32'h80000000);
    chk("R9 R10 irq held", {31'b0, irq}, 32'h1);
    wr(A_EVT, 32'h80000000);
    rd_chk("R8 later clear", A_EVT, 32'h0);

    finish_run();
  end
endmodule